// File: doc/BRIEF.md
# SPI NOR Flash Command Monitor

A passive observer placed beside a single-bit SPI NOR flash link. Its input is the result of each whole byte transfer: the byte the host drove and the byte the device returned, plus a pulse marking the release of chip-select. The first byte after reset or after a release is taken as the command opcode. A per-command byte position then decides how each later byte is used: as an address byte, a dummy byte, an order selector, an identification reply, a status byte or a data byte.

The monitor builds the 24-bit address and keeps the latest manufacturer, memory-type and device identifiers. It holds a shadow copy of the flash write-enable latch and the last status byte. It counts data-phase bytes and raises warnings: an unknown opcode, a write-type command issued while the shadow latch is clear, and a sector erase to an address that is not 4 KiB aligned. When chip-select is released, a summary of the finished transaction is offered on a valid/ready output. It stays there until the consumer accepts it.

The controller is a state machine. Its states are: `S_CMD` waits for the opcode; `S_ADDR` takes the address bytes; `S_DUMMY` skips dummy bytes; `S_SEL` takes the ID-order selector; `S_REPLY` captures identifier bytes; `S_DATA` counts read or program data; `S_STATUS` captures repeated status reads; `S_SKIP` ignores the rest of a finished or unknown command.

Transitions:
- A release moves every state to `S_CMD`.
- The opcode byte moves `S_CMD` to `S_ADDR` for 03/0B/02/20, `S_STATUS` for 05, `S_REPLY` for 9F, `S_DUMMY` for AB/90, and `S_SKIP` for all other opcodes.
- The fourth byte moves `S_ADDR` on: to `S_DATA` for 03/02, `S_DUMMY` for 0B, `S_SKIP` for 20.
- `S_DUMMY` goes to `S_DATA` after byte 5 of 0B, to `S_REPLY` after byte 4 of AB, and to `S_SEL` after byte 3 of 90.
- `S_SEL` goes to `S_REPLY` after one byte.
- `S_REPLY` goes to `S_SKIP` after its last identifier byte: byte 4 for 9F, byte 5 for AB, byte 6 for 90.

Top module: `spinor_cmd_monitor`

## Requirements
- R1: After reset, `sum_valid`, `wel_shadow`, `stat_byte` and all three identifier outputs are 0.
- R2: The first byte of a transaction is the opcode and is reported as `sum_cmd`. For opcodes 0x03, 0x0B, 0x02 and 0x20, host bytes 2, 3 and 4 form `sum_addr`, most significant byte first. Commands without an address report address 0.
- R3: For read 0x03, data bytes counted in `sum_count` start at byte 5. For fast read 0x0B, byte 5 is a dummy and counting starts at byte 6. Page program 0x02 counts from byte 5.
- R4: A summary is produced only by an `in_release` pulse that ends a transaction of at least one byte. It then holds steady until `sum_ready` is high at a clock edge. A release that arrives while an earlier summary is still pending is discarded. A byte presented in the same cycle as a release is discarded.
- R5: Opcode 0x06 sets `wel_shadow` and 0x04 clears it. During status read 0x05, every device byte after the opcode loads `stat_byte` and reloads `wel_shadow` from its bit 1. Each such byte is counted in `sum_count`.
- R6: Opcodes 0x02, 0x01, 0x20, 0x60 and 0xC7 set `sum_flags[1]` (write enable missing) when `wel_shadow` is 0 at the opcode byte.
- R7: Sector erase 0x20 sets `sum_flags[2]` when the low 12 address bits are nonzero. Bytes after its fourth byte are ignored.
- R8: Identification 0x9F loads `id_mfr`, `id_type` and `id_dev` from device bytes 2, 3 and 4.
- R9: Device ID read 0xAB ignores bytes 2 to 4 and loads `id_dev` from device byte 5.
- R10: For 0x90, host byte 4 equal to 0x00 means device byte 5 is the manufacturer ID and byte 6 the device ID. Any other value of host byte 4 swaps the two.
- R11: An unrecognised opcode sets `sum_flags[0]`. Every later byte of that transaction has no effect; for example, a 0x06 later in the transaction leaves `wel_shadow` unchanged, and the count stays 0.
- R12: `sum_count` saturates at 2^CNT_W-1 and does not wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | A byte pair is presented this cycle |
| in_host | input | 8 | Byte driven by the host |
| in_dev | input | 8 | Byte returned by the device |
| in_release | input | 1 | Chip-select release pulse; ends the transaction |
| sum_valid | output | 1 | Summary available |
| sum_ready | input | 1 | Consumer accepts the summary |
| sum_cmd | output | 8 | Opcode of the summarised transaction |
| sum_addr | output | 24 | Assembled address |
| sum_count | output | CNT_W | Data-phase byte count |
| sum_flags | output | 3 | bit0 unknown opcode, bit1 write enable missing, bit2 misaligned erase |
| wel_shadow | output | 1 | Shadow write-enable latch |
| stat_byte | output | 8 | Last status byte read |
| id_mfr | output | 8 | Last manufacturer ID |
| id_type | output | 8 | Last memory type |
| id_dev | output | 8 | Last device ID |

## Verification
The bench builds the monitor with `CNT_W` = 4, down from the default of 16. A read with twenty data bytes then pushes the counter past its ceiling of 15, so saturation is checked in a short run instead of after 65535 bytes. The byte-position logic does not depend on `CNT_W`, so the same directed scenarios cover every opcode path at either width.

// File: rtl/spinor_mon_pkg.sv
package spinor_mon_pkg;

    localparam logic [7:0] OP_WREN  = 8'h06;
    localparam logic [7:0] OP_WRDI  = 8'h04;
    localparam logic [7:0] OP_RDSR  = 8'h05;
    localparam logic [7:0] OP_WRSR  = 8'h01;
    localparam logic [7:0] OP_READ  = 8'h03;
    localparam logic [7:0] OP_FAST  = 8'h0B;
    localparam logic [7:0] OP_PP    = 8'h02;
    localparam logic [7:0] OP_SE    = 8'h20;
    localparam logic [7:0] OP_CE_A  = 8'h60;
    localparam logic [7:0] OP_CE_B  = 8'hC7;
    localparam logic [7:0] OP_RDID  = 8'h9F;
    localparam logic [7:0] OP_RES   = 8'hAB;
    localparam logic [7:0] OP_REMS  = 8'h90;

    localparam int FLAG_W     = 3;
    localparam int FLAG_UNK   = 0;
    localparam int FLAG_NOWEL = 1;
    localparam int FLAG_ALIGN = 2;

    typedef enum logic [3:0] {
        C_UNK, C_WREN, C_WRDI, C_RDSR, C_WRSR, C_READ, C_FAST,
        C_PP, C_SE, C_CE, C_RDID, C_RES, C_REMS
    } cmd_cls_e;

    typedef enum logic [3:0] {
        S_CMD, S_ADDR, S_DUMMY, S_SEL, S_REPLY, S_DATA, S_STATUS, S_SKIP
    } mon_state_e;

endpackage

// File: rtl/spinor_cmd_decode.sv
module spinor_cmd_decode
    import spinor_mon_pkg::*;
(
    input  logic [7:0] opcode,
    output cmd_cls_e   cls,
    output logic       needs_wel
);
    always_comb begin
        unique case (opcode)
            OP_WREN:          cls = C_WREN;
            OP_WRDI:          cls = C_WRDI;
            OP_RDSR:          cls = C_RDSR;
            OP_WRSR:          cls = C_WRSR;
            OP_READ:          cls = C_READ;
            OP_FAST:          cls = C_FAST;
            OP_PP:            cls = C_PP;
            OP_SE:            cls = C_SE;
            OP_CE_A, OP_CE_B: cls = C_CE;
            OP_RDID:          cls = C_RDID;
            OP_RES:           cls = C_RES;
            OP_REMS:          cls = C_REMS;
            default:          cls = C_UNK;
        endcase
        needs_wel = (cls == C_PP) || (cls == C_WRSR) || (cls == C_SE) || (cls == C_CE);
    end
endmodule

// File: rtl/spinor_sat_counter.sv
module spinor_sat_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] q
);
    localparam logic [W-1:0] TOP = {W{1'b1}};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            q <= '0;
        else if (clr)
            q <= '0;
        else if (inc && (q != TOP))
            q <= q + 1'b1;
    end
endmodule

// File: rtl/spinor_cmd_monitor.sv
module spinor_cmd_monitor
    import spinor_mon_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int POS_W = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [7:0]          in_host,
    input  logic [7:0]          in_dev,
    input  logic                in_release,
    output logic                sum_valid,
    input  logic                sum_ready,
    output logic [7:0]          sum_cmd,
    output logic [23:0]         sum_addr,
    output logic [CNT_W-1:0]    sum_count,
    output logic [FLAG_W-1:0]   sum_flags,
    output logic                wel_shadow,
    output logic [7:0]          stat_byte,
    output logic [7:0]          id_mfr,
    output logic [7:0]          id_type,
    output logic [7:0]          id_dev
);
    localparam logic [POS_W-1:0] P1 = POS_W'(1);
    localparam logic [POS_W-1:0] P2 = POS_W'(2);
    localparam logic [POS_W-1:0] P3 = POS_W'(3);
    localparam logic [POS_W-1:0] P4 = POS_W'(4);
    localparam logic [POS_W-1:0] P5 = POS_W'(5);

    mon_state_e          state, nxt;
    cmd_cls_e            dec_cls, cur_cls;
    logic                dec_wel;
    logic [7:0]          cur_op;
    logic [23:0]         cur_addr;
    logic [FLAG_W-1:0]   cur_flg;
    logic                mfr_first;
    logic [POS_W-1:0]    seen;
    logic [CNT_W-1:0]    data_cnt;
    logic                take, data_inc, load_sum;

    assign take     = in_valid && !in_release;
    assign data_inc = take && ((state == S_DATA) || (state == S_STATUS));
    assign load_sum = in_release && (state != S_CMD) && (!sum_valid || sum_ready);

    spinor_cmd_decode u_dec (
        .opcode    (in_host),
        .cls       (dec_cls),
        .needs_wel (dec_wel)
    );

    spinor_sat_counter #(.W(POS_W)) u_pos (
        .clk (clk), .rst_n (rst_n), .clr (in_release), .inc (take), .q (seen)
    );

    spinor_sat_counter #(.W(CNT_W)) u_cnt (
        .clk (clk), .rst_n (rst_n), .clr (in_release), .inc (data_inc), .q (data_cnt)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_CMD;
        else        state <= nxt;
    end

    // next-state logic
    always_comb begin
        nxt = state;
        if (in_release) begin
            nxt = S_CMD;
        end else if (in_valid) begin
            unique case (state)
                S_CMD: begin
                    unique case (dec_cls)
                        C_RDSR:                        nxt = S_STATUS;
                        C_READ, C_FAST, C_PP, C_SE:    nxt = S_ADDR;
                        C_RDID:                        nxt = S_REPLY;
                        C_RES, C_REMS:                 nxt = S_DUMMY;
                        default:                       nxt = S_SKIP;
                    endcase
                end
                S_ADDR: begin
                    if (seen == P3) begin
                        if (cur_cls == C_FAST)    nxt = S_DUMMY;
                        else if (cur_cls == C_SE) nxt = S_SKIP;
                        else                      nxt = S_DATA;
                    end
                end
                S_DUMMY: begin
                    if (cur_cls == C_FAST)                      nxt = S_DATA;
                    else if (cur_cls == C_RES && seen == P3)    nxt = S_REPLY;
                    else if (cur_cls == C_REMS && seen == P2)   nxt = S_SEL;
                end
                S_SEL:   nxt = S_REPLY;
                S_REPLY: begin
                    if ((cur_cls == C_RDID && seen == P3) ||
                        (cur_cls == C_RES) ||
                        (cur_cls == C_REMS && seen == P5))
                        nxt = S_SKIP;
                end
                S_DATA, S_STATUS, S_SKIP: nxt = state;
                default: nxt = S_CMD;
            endcase
        end
    end

    // outputs and transaction registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_cls    <= C_UNK;
            cur_op     <= '0;
            cur_addr   <= '0;
            cur_flg    <= '0;
            mfr_first  <= 1'b1;
            wel_shadow <= 1'b0;
            stat_byte  <= '0;
            id_mfr     <= '0;
            id_type    <= '0;
            id_dev     <= '0;
            sum_valid  <= 1'b0;
            sum_cmd    <= '0;
            sum_addr   <= '0;
            sum_count  <= '0;
            sum_flags  <= '0;
        end else begin
            if (sum_valid && sum_ready)
                sum_valid <= 1'b0;
            if (load_sum) begin
                sum_valid <= 1'b1;
                sum_cmd   <= cur_op;
                sum_addr  <= cur_addr;
                sum_count <= data_cnt;
                sum_flags <= cur_flg;
            end
            if (take) begin
                unique case (state)
                    S_CMD: begin
                        cur_op   <= in_host;
                        cur_cls  <= dec_cls;
                        cur_addr <= '0;
                        cur_flg  <= '0;
                        cur_flg[FLAG_UNK]   <= (dec_cls == C_UNK);
                        cur_flg[FLAG_NOWEL] <= dec_wel && !wel_shadow;
                        if (dec_cls == C_WREN) wel_shadow <= 1'b1;
                        if (dec_cls == C_WRDI) wel_shadow <= 1'b0;
                    end
                    S_ADDR: begin
                        cur_addr <= {cur_addr[15:0], in_host};
                        if (cur_cls == C_SE && seen == P3 && ({cur_addr[3:0], in_host} != 12'h000))
                            cur_flg[FLAG_ALIGN] <= 1'b1;
                    end
                    S_SEL:    mfr_first <= (in_host == 8'h00);
                    S_STATUS: begin
                        stat_byte  <= in_dev;
                        wel_shadow <= in_dev[1];
                    end
                    S_REPLY: begin
                        unique case (cur_cls)
                            C_RDID: begin
                                if (seen == P1) id_mfr  <= in_dev;
                                if (seen == P2) id_type <= in_dev;
                                if (seen == P3) id_dev  <= in_dev;
                            end
                            C_RES: id_dev <= in_dev;
                            C_REMS: begin
                                if ((seen == P4) == mfr_first) id_mfr <= in_dev;
                                else                           id_dev <= in_dev;
                            end
                            default: ;
                        endcase
                    end
                    S_DUMMY, S_DATA, S_SKIP: ;
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/spinor_mon_checker.sv
module spinor_mon_checker
    import spinor_mon_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [7:0]        in_host,
    input logic [7:0]        in_dev,
    input logic              in_release,
    input logic              sum_valid,
    input logic              sum_ready,
    input logic [7:0]        sum_cmd,
    input logic [23:0]       sum_addr,
    input logic [CNT_W-1:0]  sum_count,
    input logic [FLAG_W-1:0] sum_flags,
    input logic              wel_shadow,
    input mon_state_e        state,
    input logic [CNT_W-1:0]  data_cnt
);
    localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

    // R4: pending summary stays put until accepted
    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        sum_valid && !sum_ready |=> sum_valid && $stable(sum_cmd) && $stable(sum_addr)
                                    && $stable(sum_count) && $stable(sum_flags));

    // R4: a summary appears only after a release
    p_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sum_valid) |-> $past(in_release));

    // R5: write enable sets the shadow latch
    p_wren_r5: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && !in_release && state == S_CMD && in_host == OP_WREN |=> wel_shadow);

    // R5: write disable clears the shadow latch
    p_wrdi_r5: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && !in_release && state == S_CMD && in_host == OP_WRDI |=> !wel_shadow);

    // R5: status bytes reload the latch from bit 1
    p_stat_r5: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && !in_release && state == S_STATUS |=> wel_shadow == $past(in_dev[1]));

    // R11: ignored bytes leave the latch alone
    p_skip_r11: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && !in_release && state == S_SKIP |=> $stable(wel_shadow));

    // R12: the data counter stays at its ceiling
    p_sat_r12: assert property (@(posedge clk) disable iff (!rst_n)
        data_cnt == CMAX && !in_release |=> data_cnt == CMAX);
endmodule

bind spinor_cmd_monitor spinor_mon_checker #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_host    (in_host),
    .in_dev     (in_dev),
    .in_release (in_release),
    .sum_valid  (sum_valid),
    .sum_ready  (sum_ready),
    .sum_cmd    (sum_cmd),
    .sum_addr   (sum_addr),
    .sum_count  (sum_count),
    .sum_flags  (sum_flags),
    .wel_shadow (wel_shadow),
    .state      (state),
    .data_cnt   (data_cnt)
);

// File: tb/spinor_cmd_monitor_test.sv
`timescale 1ns/1ps
module spinor_cmd_monitor_test;
    localparam int CW = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic [7:0] in_host = '0;
    logic [7:0] in_dev = '0;
    logic in_release = 1'b0;
    logic sum_ready = 1'b0;
    logic sum_valid;
    logic [7:0] sum_cmd;
    logic [23:0] sum_addr;
    logic [CW-1:0] sum_count;
    logic [2:0] sum_flags;
    logic wel_shadow;
    logic [7:0] stat_byte, id_mfr, id_type, id_dev;

    int checks = 0;
    int fails = 0;

    always #2.5 clk = ~clk;

    spinor_cmd_monitor #(.CNT_W(CW)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_host(in_host),
        .in_dev(in_dev), .in_release(in_release), .sum_valid(sum_valid),
        .sum_ready(sum_ready), .sum_cmd(sum_cmd), .sum_addr(sum_addr),
        .sum_count(sum_count), .sum_flags(sum_flags), .wel_shadow(wel_shadow),
        .stat_byte(stat_byte), .id_mfr(id_mfr), .id_type(id_type), .id_dev(id_dev)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic xfer(input logic [7:0] h, input logic [7:0] d);
        @(negedge clk);
        in_valid = 1'b1; in_host = h; in_dev = d;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic release_cs();
        @(negedge clk);
        in_release = 1'b1;
        @(negedge clk);
        in_release = 1'b0;
    endtask

    task automatic expect_sum(input string tag, input logic [7:0] c, input logic [23:0] a,
                              input int n, input logic [2:0] f);
        check({tag, " valid"}, 32'(sum_valid), 32'd1);
        check({tag, " cmd"},   32'(sum_cmd), 32'(c));
        check({tag, " addr"},  32'(sum_addr), 32'(a));
        check({tag, " count"}, 32'(sum_count), 32'(n));
        check({tag, " flags"}, 32'(sum_flags), 32'(f));
        sum_ready = 1'b1;
        @(negedge clk);
        sum_ready = 1'b0;
        check({tag, " accepted"}, 32'(sum_valid), 32'd0);
    endtask

    task automatic t_reset();
        check("R1 valid", 32'(sum_valid), 0);
        check("R1 wel", 32'(wel_shadow), 0);
        check("R1 stat", 32'(stat_byte), 0);
        check("R1 ids", {8'h0, id_mfr, id_type, id_dev}, 0);
    endtask

    task automatic t_read();
        xfer(8'h03, 0); xfer(8'h12, 0); xfer(8'h34, 0); xfer(8'h56, 0);
        xfer(0, 8'hA0); xfer(0, 8'hA1); xfer(0, 8'hA2);
        release_cs();
        expect_sum("R2 R3 read", 8'h03, 24'h123456, 3, 3'b000);
    endtask

    task automatic t_fast();
        xfer(8'h0B, 0); xfer(8'h00, 0); xfer(8'h10, 0); xfer(8'h00, 0);
        xfer(8'hFF, 0); xfer(0, 8'h11); xfer(0, 8'h22);
        release_cs();
        expect_sum("R3 fast", 8'h0B, 24'h001000, 2, 3'b000);
    endtask

    task automatic t_program();
        xfer(8'h02, 0); xfer(8'h00, 0); xfer(8'h01, 0); xfer(8'h00, 0); xfer(8'h55, 0);
        release_cs();
        expect_sum("R6 pp nowel", 8'h02, 24'h000100, 1, 3'b010);
        xfer(8'h06, 0);
        release_cs();
        expect_sum("R5 wren", 8'h06, 0, 0, 3'b000);
        check("R5 wel set", 32'(wel_shadow), 1);
        xfer(8'h02, 0); xfer(8'hAB, 0); xfer(8'hCD, 0); xfer(8'hEF, 0);
        for (int i = 0; i < 4; i++) xfer(8'(i), 0);
        release_cs();
        expect_sum("R3 pp", 8'h02, 24'hABCDEF, 4, 3'b000);
    endtask

    task automatic t_erase();
        xfer(8'h20, 0); xfer(8'h00, 0); xfer(8'h10, 0); xfer(8'h01, 0); xfer(8'h77, 0);
        release_cs();
        expect_sum("R7 misaligned", 8'h20, 24'h001001, 0, 3'b100);
        xfer(8'h20, 0); xfer(8'h00, 0); xfer(8'h20, 0); xfer(8'h00, 0);
        release_cs();
        expect_sum("R7 aligned", 8'h20, 24'h002000, 0, 3'b000);
    endtask

    task automatic t_chip_erase();
        xfer(8'h04, 0);
        release_cs();
        expect_sum("R5 wrdi", 8'h04, 0, 0, 3'b000);
        check("R5 wel clear", 32'(wel_shadow), 0);
        xfer(8'hC7, 0);
        release_cs();
        expect_sum("R6 ce", 8'hC7, 0, 0, 3'b010);
    endtask

    task automatic t_status();
        xfer(8'h05, 0);
        xfer(0, 8'h02);
        check("R5 stat wel1", 32'(wel_shadow), 1);
        check("R5 stat byte", 32'(stat_byte), 32'h02);
        xfer(0, 8'hFD);
        check("R5 stat wel0", 32'(wel_shadow), 0);
        check("R5 stat byte2", 32'(stat_byte), 32'hFD);
        release_cs();
        expect_sum("R5 rdsr", 8'h05, 0, 2, 3'b000);
    endtask

    task automatic t_ids();
        xfer(8'h9F, 0); xfer(0, 8'hEF); xfer(0, 8'h40); xfer(0, 8'h17); xfer(0, 8'h99);
        release_cs();
        check("R8 mfr", 32'(id_mfr), 32'hEF);
        check("R8 type", 32'(id_type), 32'h40);
        check("R8 dev", 32'(id_dev), 32'h17);
        expect_sum("R8 rdid", 8'h9F, 0, 0, 3'b000);
        xfer(8'hAB, 0); xfer(0, 8'h01); xfer(0, 8'h02); xfer(0, 8'h03); xfer(0, 8'h55);
        release_cs();
        check("R9 dev", 32'(id_dev), 32'h55);
        check("R9 mfr kept", 32'(id_mfr), 32'hEF);
        expect_sum("R9 res", 8'hAB, 0, 0, 3'b000);
        xfer(8'h90, 0); xfer(0, 0); xfer(0, 0); xfer(8'h00, 0); xfer(0, 8'hC2); xfer(0, 8'h18);
        release_cs();
        check("R10 mfr first mfr", 32'(id_mfr), 32'hC2);
        check("R10 mfr first dev", 32'(id_dev), 32'h18);
        expect_sum("R10 rems0", 8'h90, 0, 0, 3'b000);
        xfer(8'h90, 0); xfer(0, 0); xfer(0, 0); xfer(8'h01, 0); xfer(0, 8'hA1); xfer(0, 8'hB2);
        release_cs();
        check("R10 dev first dev", 32'(id_dev), 32'hA1);
        check("R10 dev first mfr", 32'(id_mfr), 32'hB2);
        expect_sum("R10 rems1", 8'h90, 0, 0, 3'b000);
    endtask

    task automatic t_unknown();
        xfer(8'hFF, 0); xfer(8'h06, 0); xfer(8'h03, 0);
        check("R11 wel untouched", 32'(wel_shadow), 0);
        release_cs();
        expect_sum("R11 unknown", 8'hFF, 0, 0, 3'b001);
    endtask

    task automatic t_saturate();
        xfer(8'h03, 0); xfer(0, 0); xfer(0, 0); xfer(8'h08, 0);
        for (int i = 0; i < 20; i++) xfer(0, 8'(i));
        release_cs();
        expect_sum("R12 saturate", 8'h03, 24'h000008, 15, 3'b000);
    endtask

    task automatic t_hold();
        xfer(8'h03, 0); xfer(0, 0); xfer(0, 0); xfer(8'h01, 0); xfer(0, 8'h3C);
        release_cs();
        repeat (3) @(negedge clk);
        check("R4 held valid", 32'(sum_valid), 1);
        xfer(8'h06, 0);
        release_cs();
        check("R4 held cmd", 32'(sum_cmd), 32'h03);
        expect_sum("R4 held", 8'h03, 24'h000001, 1, 3'b000);
        repeat (2) @(negedge clk);
        check("R4 second dropped", 32'(sum_valid), 0);
        release_cs();
        check("R4 empty release", 32'(sum_valid), 0);
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        #(5.0 * 150000);
        fails++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_read();
        t_fast();
        t_program();
        t_erase();
        t_chip_erase();
        t_status();
        t_ids();
        t_unknown();
        t_saturate();
        t_hold();
        finish_run();
    end
endmodule